// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Port

This block moves one byte at a time over three wires: a serial clock, a data-out line and a data-in line. A single shift register holds the byte. It shifts its most significant bit out while it shifts the incoming line in at the bottom, so each transfer swaps the byte with the device on the other end. Software writes the byte, selects the role and rate in a control register, and sets a busy flag in the status register to start. When the eighth bit has moved, busy drops, a pending flag rises and, if enabled, an interrupt is raised. Chip selects are driven from ordinary port pins elsewhere.

As clock master the block generates the serial clock from the core clock. Two rate bits select a divider of 2, 4, 8 or 16. As clock slave it synchronises an external serial clock into the core domain. In both roles a transfer completes after eight clock periods.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, register reads return 0 at address 0 (data), address 1 (control) and address 2 (status). `sck_o`, `sck_oe` and `irq_o` are low.
- R2: In master mode, writing 1 to status bit 0 while idle starts a transfer. `sck_o` then gives exactly eight high pulses with a period of (2 << rate) core cycles, high for half the period and low for the other half. Rate is control bits 1:0.
- R3: `so_o` presents the byte most significant bit first. It changes only on a falling serial clock edge and stays steady through each high phase.
- R4: The data-in line is sampled on each rising serial clock edge. After the transfer, the data register (address 0) holds the received bits with the first one sampled in bit 7.
- R5: Status bit 0 (busy) reads 1 during a transfer. It clears after the eighth falling edge, and status bit 1 (pending) is set at the same time.
- R6: `irq_o` is high exactly while pending is set and control bit 3 (interrupt enable) is 1. Writing 1 to status bit 1 clears pending.
- R7: With control bit 2 clear (slave mode), `sck_oe` and `sck_o` stay low. Eight rising and falling edges on `sck_i` complete a transfer that exchanges data as in R3 and R4.
- R8: Edges on `sck_i` while busy is clear leave the data register and pending unchanged.
- R9: Writes to the data or control register while busy are ignored.
- R10: The control register reads back the value written while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for `reg_addr`, one cycle later |
| irq_o | output | 1 | Completion interrupt |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable (master mode) |
| sck_i | input | 1 | External serial clock for slave mode |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |

## Verification
The bench builds the block at its defaults: an 8-bit shift register, a 2-bit rate field and a two-stage synchroniser. At the fastest master rate it sweeps all 256 transmit bytes, each against a derived receive byte, and checks the swap in both directions together with the clock shape of every transfer. At the three slower rates it covers the half-period counter limits. Slave transfers, idle clock edges, writes blocked while busy and the interrupt-enable gate are exercised with a behavioural partner model on the serial pins.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam int ST_BUSY = 0;
  localparam int ST_PEND = 1;
endpackage

// File: rtl/ssp_master_clk.sv
module ssp_master_clk #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              sck,
  output logic              rise,
  output logic              fall
);
  localparam int CNT_W = (1 << RATE_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             sck_q;
  logic             tick;

  assign half_m1 = (CNT_W'(1) << rate) - CNT_W'(1);
  assign tick    = run && (cnt == half_m1);
  assign rise    = tick && !sck_q;
  assign fall    = tick && sck_q;
  assign sck     = sck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= half_m1)); // R2

endmodule

// File: rtl/ssp_slave_edge.sv
module ssp_slave_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic si_in,
  output logic rise,
  output logic fall,
  output logic si_sync
);
  localparam int CH = SYNC_STAGES + 1;

  logic [CH-1:0]          sck_ch;
  logic [SYNC_STAGES-1:0] si_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_ch <= '0;
      si_ch  <= '0;
    end else begin
      sck_ch[0] <= sck_in;
      si_ch[0]  <= si_in;
      for (int k = 1; k < CH; k++) sck_ch[k] <= sck_ch[k-1];
      for (int k = 1; k < SYNC_STAGES; k++) si_ch[k] <= si_ch[k-1];
    end
  end

  assign rise    = sck_ch[CH-2] && !sck_ch[CH-1];
  assign fall    = !sck_ch[CH-2] && sck_ch[CH-1];
  assign si_sync = si_ch[SYNC_STAGES-1];

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          clr,
  input  logic          sample_en,
  input  logic          shift_en,
  input  logic          si,
  output logic [DW-1:0] data,
  output logic          so,
  output logic          done
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [CW-1:0] cnt;
  logic          samp;

  assign done = shift_en && (cnt == CW'(DW-1));
  assign so   = data[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      cnt  <= '0;
      samp <= 1'b0;
    end else begin
      if (load) data <= load_val;
      if (clr) cnt <= '0;
      if (sample_en) samp <= si;
      if (shift_en) begin
        data <= {data[DW-2:0], samp};
        cnt  <= done ? '0 : cnt + CW'(1);
      end
    end
  end

  AST_SHIFT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (run && !shift_en && !load) |=> $stable(data)); // R3

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W      = 8,
  parameter int RATE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic [ssp_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       irq_o,
  output logic                       sck_o,
  output logic                       sck_oe,
  input  logic                       sck_i,
  output logic                       so_o,
  input  logic                       si_i
);
  import ssp_pkg::*;

  localparam int CTRL_W = RATE_W + 2;

  logic [RATE_W-1:0] rate_q;
  logic              master_q;
  logic              ie_q;
  logic              busy_q;
  logic              pend_q;
  logic              irq_q;
  logic [DATA_W-1:0] rd_q;

  logic m_sck, m_rise, m_fall;
  logic s_rise, s_fall, s_si;
  logic rise, fall, si_sel, done;
  logic wr_data, wr_ctrl, wr_stat, start;
  logic [DATA_W-1:0] sh_data;

  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign start   = wr_stat && reg_wdata[ST_BUSY] && !busy_q;

  ssp_master_clk #(.RATE_W(RATE_W)) u_mclk (
    .clk (clk),
    .rst (rst),
    .run (busy_q && master_q),
    .rate(rate_q),
    .sck (m_sck),
    .rise(m_rise),
    .fall(m_fall)
  );

  ssp_slave_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sedge (
    .clk    (clk),
    .rst    (rst),
    .sck_in (sck_i),
    .si_in  (si_i),
    .rise   (s_rise),
    .fall   (s_fall),
    .si_sync(s_si)
  );

  assign rise   = busy_q && (master_q ? m_rise : s_rise);
  assign fall   = busy_q && (master_q ? m_fall : s_fall);
  assign si_sel = master_q ? si_i : s_si;

  ssp_shifter #(.DW(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .run      (busy_q),
    .load     (wr_data && !busy_q),
    .load_val (reg_wdata),
    .clr      (start),
    .sample_en(rise),
    .shift_en (fall),
    .si       (si_sel),
    .data     (sh_data),
    .so       (so_o),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q   <= '0;
      master_q <= 1'b0;
      ie_q     <= 1'b0;
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
      rd_q     <= '0;
    end else begin
      if (wr_ctrl && !busy_q) begin
        rate_q   <= reg_wdata[RATE_W-1:0];
        master_q <= reg_wdata[RATE_W];
        ie_q     <= reg_wdata[RATE_W+1];
      end
      if (wr_stat && reg_wdata[ST_PEND]) pend_q <= 1'b0;
      if (done) begin
        busy_q <= 1'b0;
        pend_q <= 1'b1;
      end else if (start) begin
        busy_q <= 1'b1;
      end
      irq_q <= pend_q && ie_q;
      case (reg_addr)
        A_DATA:  rd_q <= sh_data;
        A_CTRL:  rd_q <= DATA_W'({ie_q, master_q, rate_q});
        A_STAT:  rd_q <= DATA_W'({pend_q, busy_q});
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq_o   = irq_q;
  assign sck_o   = m_sck;
  assign sck_oe  = master_q;

  AST_DONE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    done |=> (pend_q && !busy_q)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ie_q |=> !irq_o); // R6
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !master_q |-> (!sck_oe && !sck_o)); // R7
  AST_IDLE_EDGES_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !wr_data) |=> $stable(sh_data)); // R8
  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_data && !fall) |=> $stable(sh_data)); // R9
  AST_CTRL_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_ctrl) |=> $stable({ie_q, master_q, rate_q})); // R9

  initial begin
    AST_CTRL_FITS: assert (CTRL_W <= DATA_W); // R10
  end

endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] rd_data;
  logic       irq_o, sck_o, sck_oe, so_o;
  logic       sck_s = 1'b0;
  logic       si_m = 1'b0;
  logic       si_s = 1'b0;
  logic       slave_phase = 1'b0;
  logic       si_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic       mon_on = 1'b0;
  logic [7:0] mon_rx;
  logic [7:0] mon_cap;
  int         mon_rises, mon_falls, mon_per_err, mon_so_err, mon_d, mon_last;
  logic       prev_sck = 1'b0;
  logic       prev_so = 1'b0;

  assign si_i = slave_phase ? si_s : si_m;

  always #2.5 clk = ~clk;

  sync_serial_port dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .irq_o(irq_o),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_s), .so_o(so_o), .si_i(si_i)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // partner device model for master transfers
  always @(negedge clk) begin
    if (mon_on) begin
      if (sck_o && !prev_sck) begin
        if (mon_rises > 0 && (cyc - mon_last) != mon_d) mon_per_err++;
        mon_last = cyc;
        mon_rises++;
        mon_cap = {mon_cap[6:0], so_o};
      end else if (!sck_o && prev_sck) begin
        if ((cyc - mon_last) != mon_d / 2) mon_per_err++;
        mon_falls++;
        if (mon_falls < 8) si_m = mon_rx[7 - mon_falls];
      end else if (sck_o && so_o != prev_so) begin
        mon_so_err++;
      end
      prev_so = so_o;
    end
    prev_sck = sck_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_irq(output bit got);
    got = 1'b0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (irq_o) begin got = 1'b1; break; end
    end
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx,
                             input int rate, input bit poke);
    logic [7:0] v;
    bit got;
    wr(2'd0, tx);
    mon_rx = rx; si_m = rx[7]; mon_cap = 8'h00;
    mon_rises = 0; mon_falls = 0; mon_per_err = 0; mon_so_err = 0;
    mon_d = 2 << rate; mon_last = 0; prev_so = so_o;
    mon_on = 1'b1;
    wr(2'd2, 8'h01);
    if (poke) begin
      rd(2'd2, v);
      chk(v[0] == 1'b1, "R5 busy during transfer", v, 1);
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'h00);
    end
    wait_irq(got);
    mon_on = 1'b0;
    chk(got, "R6 irq after transfer", got, 1);
    chk(mon_rises == 8 && mon_falls == 8, "R2 pulse count", mon_rises, 8);
    chk(mon_per_err == 0, "R2 clock period", mon_per_err, 0);
    chk(mon_so_err == 0 && mon_cap == tx, "R3 serial out byte", mon_cap, tx);
    rd(2'd0, v);
    chk(v == rx, poke ? "R9 data write ignored" : "R4 received byte", v, rx);
    rd(2'd2, v);
    chk(v == 8'h02, "R5 status after done", v, 2);
    if (poke) begin
      rd(2'd1, v);
      chk(v[2:0] == {1'b1, rate[1:0]}, "R9 ctrl write ignored", v, {1'b1, rate[1:0]});
    end
    wr(2'd2, 8'h02);
    @(negedge clk);
    chk(irq_o == 1'b0, "R6 irq cleared", irq_o, 0);
  endtask

  task automatic slave_edges(input logic [7:0] rx, output logic [7:0] cap);
    cap = 8'h00;
    si_s = rx[7];
    for (int b = 0; b < 8; b++) begin
      repeat (4) @(negedge clk);
      cap = {cap[6:0], so_o};
      sck_s = 1'b1;
      repeat (4) @(negedge clk);
      sck_s = 1'b0;
      if (b < 7) si_s = rx[6 - b];
    end
  endtask

  initial begin
    logic [7:0] v, cap;
    bit got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, v); chk(v == 8'h00, "R1 data reset", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R1 status reset", v, 0);
    chk(!sck_o && !sck_oe && !irq_o, "R1 pins reset", {sck_o, sck_oe, irq_o}, 0);

    wr(2'd1, 8'h0C);
    rd(2'd1, v); chk(v == 8'h0C, "R10 ctrl readback", v, 8'h0C);
    for (int i = 0; i < 256; i++)
      master_xfer(i[7:0], ~(i[7:0]) ^ 8'h5A, 0, 1'b0);

    for (int r = 1; r < 4; r++) begin
      wr(2'd1, 8'h0C | r[7:0]);
      rd(2'd1, v); chk(v == (8'h0C | r[7:0]), "R10 ctrl readback rate", v, 8'h0C | r);
      master_xfer(8'hA5, 8'h3C, r, 1'b0);
      master_xfer(8'h81, 8'h7E, r, 1'b1);
    end

    // interrupt disabled
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h96);
    wr(2'd2, 8'h01);
    repeat (40) @(negedge clk);
    chk(irq_o == 1'b0, "R6 irq masked", irq_o, 0);
    rd(2'd2, v); chk(v == 8'h02, "R6 pending without enable", v, 2);
    wr(2'd2, 8'h02);
    rd(2'd2, v); chk(v == 8'h00, "R6 pending clear", v, 0);

    // slave mode
    slave_phase = 1'b1;
    wr(2'd1, 8'h08);
    chk(!sck_oe && !sck_o, "R7 slave clock off", {sck_oe, sck_o}, 0);
    wr(2'd0, 8'h3C);
    slave_edges(8'hF0, cap);
    repeat (6) @(negedge clk);
    rd(2'd0, v); chk(v == 8'h3C, "R8 idle edges ignored", v, 8'h3C);
    rd(2'd2, v); chk(v == 8'h00, "R8 no pending", v, 0);
    wr(2'd2, 8'h01);
    slave_edges(8'h6B, cap);
    wait_irq(got);
    chk(got, "R7 slave completion", got, 1);
    chk(cap == 8'h3C, "R7 slave serial out", cap, 8'h3C);
    rd(2'd0, v); chk(v == 8'h6B, "R7 slave received", v, 8'h6B);
    chk(!sck_o, "R7 sck stays low", sck_o, 0);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'hC3);
    wr(2'd2, 8'h01);
    slave_edges(8'h01, cap);
    wait_irq(got);
    rd(2'd0, v); chk(v == 8'h01 && cap == 8'hC3, "R7 slave second", v, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule